// File: doc/BRIEF.md
# Control Endpoint Zero OUT Receive Handler

This block sits between a USB packet layer and a small microcontroller on the device side of a USB function. The packet layer delivers decoded events: a token with its kind and endpoint number, then the data packet that follows. The data packet arrives as a start strobe carrying the DATA0/DATA1 PID, a stream of payload bytes, and an end strobe that carries the CRC and bit-stuff error flags. For endpoint 0, the block decides whether the payload is accepted. Accepted control-request payloads go to an 8-byte request buffer. Ordinary OUT payloads go to the endpoint buffer. The block then reports which handshake the packet layer must return: ACK, NAK, STALL or silence.

The microcontroller owns the per-endpoint control bits. These are the receive-hold bit, which makes the block NAK further packets, the halt bits for both directions of endpoint 0, and the expected data toggle. It reads the byte count of the last accepted packet and both buffers through a read port. It is told of new data by two interrupt lines, one for control requests and one for ordinary OUT data. While a received control request is still pending, every OUT data or status packet is refused with NAK. This holds whatever the hold and halt bits say. The microcontroller releases the pending request by clearing the request interrupt.

Top module: `usbc_ep0_out`

## Requirements
- R1: An error-free OUT packet to endpoint 0 is accepted when no request is pending, halt is 0, hold is 0 and its PID matches the expected toggle (toggle 0 expects DATA0, toggle 1 expects DATA1). On acceptance the payload is stored at endpoint buffer addresses 0 upward, `data_count` takes the byte count, the toggle inverts, hold becomes 1, the handshake is ACK and `ep_irq` rises.
- R2: With hold at 1, an OUT packet gets NAK. The endpoint buffer, `data_count`, the toggle and `ep_irq` keep their values.
- R3: With halt at 1 and no request pending, an OUT packet gets STALL. This holds even when hold is also 1.
- R4: A CRC or bit-stuff error flag at packet end gives handshake code NONE, whatever the endpoint bits say. No count, toggle, hold, flag or interrupt changes. Bytes of a packet that could have been accepted may already sit in the buffer.
- R5: An error-free SETUP token plus 8-byte packet to endpoint 0 is always ACKed, even with hold or halt set. Its bytes are stored at request buffer addresses 0..7. Acceptance sets `setup_pending` and `setup_irq`, clears both halt bits and sets the toggle to 1.
- R6: While `setup_pending` is 1, an error-free OUT packet gets NAK, even with halt set or hold cleared, and nothing is stored.
- R7: Pulsing `setup_irq_clr` clears both `setup_irq` and `setup_pending`.
- R8: A configuration write that clears hold re-enables reception, so the next matching OUT packet is accepted.
- R9: An OUT payload longer than `cfg_size` (clamped to the buffer depth) gives NONE. A SETUP payload of any length other than 8 also gives NONE. Neither changes count, toggle or interrupts.
- R10: An otherwise acceptable OUT packet whose PID differs from the expected toggle is ACKed and discarded. The buffer, count, toggle, hold and `ep_irq` are left unchanged.
- R11: A data packet that follows a token for another endpoint, or follows an IN or SOF token, produces no `hs_valid` pulse. Token kind codes are 0 OUT, 1 IN, 2 SETUP and 3 SOF.
- R12: `hs_valid` is a single-cycle pulse in the cycle after `pkt_end` is sampled. `hs_code` then holds 0 NONE, 1 ACK, 2 NAK or 3 STALL.
- R13: After reset, hold is 1. Halt bits, toggle, `setup_pending`, `data_count` and both interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | Token event strobe |
| tok_kind | input | 2 | Token kind: 0 OUT, 1 IN, 2 SETUP, 3 SOF |
| tok_ep | input | 4 | Token endpoint number |
| pkt_start | input | 1 | Data packet start strobe |
| pkt_data1 | input | 1 | PID of the starting packet is DATA1 |
| rx_valid | input | 1 | Payload byte strobe |
| rx_byte | input | 8 | Payload byte |
| pkt_end | input | 1 | Data packet end strobe (carries no byte) |
| crc_err | input | 1 | CRC error flag, valid with pkt_end |
| stuff_err | input | 1 | Bit-stuff error flag, valid with pkt_end |
| cfg_size | input | CNT_W | Programmed OUT buffer size in bytes |
| cfg_we | input | 1 | Write strobe for the four control bits below |
| cfg_nack | input | 1 | New receive-hold value |
| cfg_stall | input | 1 | New OUT halt value |
| cfg_toggle | input | 1 | New expected toggle value |
| cfg_in_stall | input | 1 | New IN halt value |
| ep_irq_clr | input | 1 | Clear OUT data interrupt |
| setup_irq_clr | input | 1 | Clear request interrupt and pending flag |
| rd_setup | input | 1 | Read port selects request buffer |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Read data (combinational) |
| hs_valid | output | 1 | Handshake decision strobe |
| hs_code | output | 2 | Handshake: 0 NONE, 1 ACK, 2 NAK, 3 STALL |
| ep_nack | output | 1 | Receive-hold bit |
| ep_stall | output | 1 | OUT halt bit |
| ep_toggle | output | 1 | Expected data toggle |
| in_ep_stall | output | 1 | IN halt bit |
| setup_pending | output | 1 | Control request pending |
| data_count | output | CNT_W | Byte count of last accepted OUT packet |
| ep_irq | output | 1 | OUT data interrupt |
| setup_irq | output | 1 | Control request interrupt |

## Verification
The hardest situation to reach is the overlap of refusal conditions. A request is pending while halt is set and hold is clear, and a packet arrives with a toggle mismatch or an overflowing length. Only the priority order then decides the handshake. Directed sequences construct this state on purpose: a SETUP packet first clears halt, the microcontroller port then re-arms halt and drops hold, and further OUT packets follow. A seeded random phase then interleaves configuration writes, interrupt clears and packets with random lengths, PIDs, endpoints and error flags. This reaches the remaining combinations, and a bench-side model predicts each handshake.

// File: rtl/usbc_ep0_pkg.sv
package usbc_ep0_pkg;

    localparam int SETUP_BYTES = 8;
    localparam logic [3:0] CTRL_EP = 4'd0;

    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_e;

    typedef enum logic [1:0] {
        TK_OUT   = 2'd0,
        TK_IN    = 2'd1,
        TK_SETUP = 2'd2,
        TK_SOF   = 2'd3
    } tok_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_ARMED,
        RX_DATA
    } rx_st_e;

    // Conditions frozen when a data packet starts
    typedef struct packed {
        logic is_setup;
        logic blk_setup;
        logic blk_stall;
        logic blk_nack;
        logic seq_bad;
    } rx_ctx_t;

    typedef struct packed {
        hs_e  hs;
        logic accept;
    } verdict_t;

    function automatic logic ctx_writable(rx_ctx_t c);
        return c.is_setup | ~(c.blk_setup | c.blk_stall | c.blk_nack | c.seq_bad);
    endfunction

    // Handshake priority: error, request pending, halt, hold, toggle
    function automatic verdict_t judge(rx_ctx_t c, logic bad);
        verdict_t v;
        if (bad)              v = '{hs: HS_NONE,  accept: 1'b0};
        else if (c.is_setup)  v = '{hs: HS_ACK,   accept: 1'b1};
        else if (c.blk_setup) v = '{hs: HS_NAK,   accept: 1'b0};
        else if (c.blk_stall) v = '{hs: HS_STALL, accept: 1'b0};
        else if (c.blk_nack)  v = '{hs: HS_NAK,   accept: 1'b0};
        else if (c.seq_bad)   v = '{hs: HS_ACK,   accept: 1'b0};
        else                  v = '{hs: HS_ACK,   accept: 1'b1};
        return v;
    endfunction

endpackage

// File: rtl/usbc_ep0_mem.sv
module usbc_ep0_mem #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/usbc_ep0_rx.sv
module usbc_ep0_rx
    import usbc_ep0_pkg::*;
#(
    parameter int EP_BYTES = 64,
    parameter int CNT_W    = 7,
    parameter int AW       = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tok_valid,
    input  tok_e             tok_kind,
    input  logic [3:0]       tok_ep,
    input  logic             pkt_start,
    input  logic             pkt_data1,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             pkt_end,
    input  logic             crc_err,
    input  logic             stuff_err,
    input  logic [CNT_W-1:0] cfg_size,
    input  logic             setup_pending,
    input  logic             ep_nack,
    input  logic             ep_stall,
    input  logic             ep_toggle,
    output logic             wr_en,
    output logic             wr_setup,
    output logic [AW-1:0]    wr_addr,
    output logic [7:0]       wr_data,
    output logic             done_valid,
    output verdict_t         done_v,
    output logic             done_setup,
    output logic [CNT_W-1:0] done_count
);

    localparam logic [CNT_W-1:0] EP_LIM  = CNT_W'(EP_BYTES);
    localparam logic [CNT_W-1:0] SET_LIM = CNT_W'(SETUP_BYTES);

    rx_st_e           st;
    logic             arm_setup;
    rx_ctx_t          ctx;
    logic [CNT_W-1:0] cnt;
    logic             ovf;

    logic [CNT_W-1:0] ep_lim, lim;
    logic             room, bad, short_setup, tok_hit;

    assign ep_lim      = (cfg_size > EP_LIM) ? EP_LIM : cfg_size;
    assign lim         = ctx.is_setup ? SET_LIM : ep_lim;
    assign room        = cnt < lim;
    assign short_setup = ctx.is_setup && (cnt != SET_LIM);
    assign bad         = crc_err | stuff_err | ovf | short_setup;
    assign tok_hit     = (tok_ep == CTRL_EP) && (tok_kind == TK_OUT || tok_kind == TK_SETUP);

    assign wr_en      = (st == RX_DATA) && rx_valid && !pkt_end && room && ctx_writable(ctx);
    assign wr_setup   = ctx.is_setup;
    assign wr_addr    = cnt[AW-1:0];
    assign wr_data    = rx_byte;

    assign done_valid = (st == RX_DATA) && pkt_end;
    assign done_v     = judge(ctx, bad);
    assign done_setup = ctx.is_setup;
    assign done_count = cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= RX_IDLE;
            arm_setup <= 1'b0;
            ctx       <= '0;
            cnt       <= '0;
            ovf       <= 1'b0;
        end else if (tok_valid) begin
            st        <= tok_hit ? RX_ARMED : RX_IDLE;
            arm_setup <= (tok_kind == TK_SETUP);
        end else begin
            case (st)
                RX_ARMED: begin
                    if (pkt_start) begin
                        st            <= RX_DATA;
                        ctx.is_setup  <= arm_setup;
                        ctx.blk_setup <= setup_pending;
                        ctx.blk_stall <= ep_stall;
                        ctx.blk_nack  <= ep_nack;
                        ctx.seq_bad   <= (pkt_data1 != ep_toggle);
                        cnt           <= '0;
                        ovf           <= 1'b0;
                    end
                end
                RX_DATA: begin
                    if (pkt_end) begin
                        st <= RX_IDLE;
                    end else if (rx_valid) begin
                        if (room) cnt <= cnt + 1'b1;
                        else      ovf <= 1'b1;
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/usbc_ep0_regs.sv
module usbc_ep0_regs
    import usbc_ep0_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             cfg_nack,
    input  logic             cfg_stall,
    input  logic             cfg_toggle,
    input  logic             cfg_in_stall,
    input  logic             ep_irq_clr,
    input  logic             setup_irq_clr,
    input  logic             done_valid,
    input  verdict_t         done_v,
    input  logic             done_setup,
    input  logic [CNT_W-1:0] done_count,
    output logic             hs_valid,
    output hs_e              hs_code,
    output logic             ep_nack,
    output logic             ep_stall,
    output logic             ep_toggle,
    output logic             in_ep_stall,
    output logic             setup_pending,
    output logic [CNT_W-1:0] data_count,
    output logic             ep_irq,
    output logic             setup_irq
);

    logic take_setup, take_data;

    assign take_setup = done_valid && done_v.accept && done_setup;
    assign take_data  = done_valid && done_v.accept && !done_setup;

    // Microcontroller writes apply first; receive events override them
    always_ff @(posedge clk) begin
        if (rst) begin
            hs_valid      <= 1'b0;
            hs_code       <= HS_NONE;
            ep_nack       <= 1'b1;
            ep_stall      <= 1'b0;
            ep_toggle     <= 1'b0;
            in_ep_stall   <= 1'b0;
            setup_pending <= 1'b0;
            data_count    <= '0;
            ep_irq        <= 1'b0;
            setup_irq     <= 1'b0;
        end else begin
            hs_valid <= done_valid;
            if (done_valid) hs_code <= done_v.hs;

            if (cfg_we) begin
                ep_nack     <= cfg_nack;
                ep_stall    <= cfg_stall;
                ep_toggle   <= cfg_toggle;
                in_ep_stall <= cfg_in_stall;
            end
            if (ep_irq_clr) ep_irq <= 1'b0;
            if (setup_irq_clr) begin
                setup_irq     <= 1'b0;
                setup_pending <= 1'b0;
            end

            if (take_setup) begin
                setup_pending <= 1'b1;
                setup_irq     <= 1'b1;
                ep_stall      <= 1'b0;
                in_ep_stall   <= 1'b0;
                ep_toggle     <= 1'b1;
            end
            if (take_data) begin
                data_count <= done_count;
                ep_toggle  <= ~ep_toggle;
                ep_nack    <= 1'b1;
                ep_irq     <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/usbc_ep0_out.sv
module usbc_ep0_out
    import usbc_ep0_pkg::*;
#(
    parameter int  EP_BYTES = 64,
    localparam int CNT_W    = $clog2(EP_BYTES + 1),
    localparam int AW       = $clog2(EP_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tok_valid,
    input  logic [1:0]       tok_kind,
    input  logic [3:0]       tok_ep,
    input  logic             pkt_start,
    input  logic             pkt_data1,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             pkt_end,
    input  logic             crc_err,
    input  logic             stuff_err,
    input  logic [CNT_W-1:0] cfg_size,
    input  logic             cfg_we,
    input  logic             cfg_nack,
    input  logic             cfg_stall,
    input  logic             cfg_toggle,
    input  logic             cfg_in_stall,
    input  logic             ep_irq_clr,
    input  logic             setup_irq_clr,
    input  logic             rd_setup,
    input  logic [AW-1:0]    rd_addr,
    output logic [7:0]       rd_data,
    output logic             hs_valid,
    output logic [1:0]       hs_code,
    output logic             ep_nack,
    output logic             ep_stall,
    output logic             ep_toggle,
    output logic             in_ep_stall,
    output logic             setup_pending,
    output logic [CNT_W-1:0] data_count,
    output logic             ep_irq,
    output logic             setup_irq
);

    localparam int SAW = $clog2(SETUP_BYTES);

    logic             wr_en, wr_setup;
    logic [AW-1:0]    wr_addr;
    logic [7:0]       wr_data;
    logic             done_valid, done_setup;
    verdict_t         done_v;
    logic [CNT_W-1:0] done_count;
    hs_e              hs_q;
    logic [7:0]       ep_q, set_q;

    usbc_ep0_rx #(
        .EP_BYTES(EP_BYTES), .CNT_W(CNT_W), .AW(AW)
    ) u_rx (
        .clk, .rst, .tok_valid,
        .tok_kind(tok_e'(tok_kind)), .tok_ep,
        .pkt_start, .pkt_data1, .rx_valid, .rx_byte,
        .pkt_end, .crc_err, .stuff_err, .cfg_size,
        .setup_pending, .ep_nack, .ep_stall, .ep_toggle,
        .wr_en, .wr_setup, .wr_addr, .wr_data,
        .done_valid, .done_v, .done_setup, .done_count
    );

    usbc_ep0_regs #(.CNT_W(CNT_W)) u_regs (
        .clk, .rst, .cfg_we, .cfg_nack, .cfg_stall, .cfg_toggle,
        .cfg_in_stall, .ep_irq_clr, .setup_irq_clr,
        .done_valid, .done_v, .done_setup, .done_count,
        .hs_valid, .hs_code(hs_q), .ep_nack, .ep_stall, .ep_toggle,
        .in_ep_stall, .setup_pending, .data_count, .ep_irq, .setup_irq
    );

    usbc_ep0_mem #(.DEPTH(EP_BYTES)) u_ep_buf (
        .clk, .we(wr_en && !wr_setup), .waddr(wr_addr), .wdata(wr_data),
        .raddr(rd_addr), .rdata(ep_q)
    );

    usbc_ep0_mem #(.DEPTH(SETUP_BYTES)) u_req_buf (
        .clk, .we(wr_en && wr_setup), .waddr(wr_addr[SAW-1:0]), .wdata(wr_data),
        .raddr(rd_addr[SAW-1:0]), .rdata(set_q)
    );

    assign rd_data = rd_setup ? set_q : ep_q;
    assign hs_code = hs_q;

endmodule

// File: rtl/usbc_ep0_out_chk.sv
module usbc_ep0_out_chk #(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             pkt_end,
    input logic             setup_irq_clr,
    input logic             hs_valid,
    input logic [1:0]       hs_code,
    input logic             ep_nack,
    input logic             ep_stall,
    input logic             ep_toggle,
    input logic             in_ep_stall,
    input logic             setup_pending,
    input logic [CNT_W-1:0] data_count,
    input logic             ep_irq,
    input logic             setup_irq
);

    AST_HS_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        hs_valid |-> $past(pkt_end)); // R12

    AST_ACCEPT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (hs_valid && hs_code == 2'd1 && $rose(ep_irq)) |-> ep_nack); // R1

    AST_NAK_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (hs_valid && hs_code == 2'd2) |-> ($stable(data_count) && !$rose(ep_irq))); // R2

    AST_SILENT_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        (hs_valid && hs_code == 2'd0) |-> (!$rose(ep_irq) && !$rose(setup_irq))); // R4

    AST_STALL_NOT_PENDING: assert property (@(posedge clk) disable iff (rst)
        (hs_valid && hs_code == 2'd3) |-> !setup_pending); // R6

    AST_REQ_CLEARS_HALT: assert property (@(posedge clk) disable iff (rst)
        $rose(setup_pending) |-> (!ep_stall && !in_ep_stall && ep_toggle && setup_irq)); // R5

    AST_IRQ_CLR_FLAG: assert property (@(posedge clk) disable iff (rst)
        $fell(setup_irq) |-> !setup_pending); // R7

    AST_CLR_REQ: assert property (@(posedge clk) disable iff (rst)
        (setup_irq_clr && !pkt_end) |=> !setup_irq); // R7

endmodule

bind usbc_ep0_out usbc_ep0_out_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_usbc_ep0_out.sv
`timescale 1ns/100ps
module tb_usbc_ep0_out;

    localparam int EPB = 64;
    localparam int CW  = $clog2(EPB + 1);
    localparam int AWB = $clog2(EPB);

    logic clk = 1'b0;
    logic rst;
    logic tok_valid = 0, pkt_start = 0, pkt_data1 = 0, rx_valid = 0, pkt_end = 0;
    logic crc_err = 0, stuff_err = 0;
    logic [1:0] tok_kind = 0;
    logic [3:0] tok_ep = 0;
    logic [7:0] rx_byte = 0;
    logic [CW-1:0] cfg_size = CW'(EPB);
    logic cfg_we = 0, cfg_nack = 0, cfg_stall = 0, cfg_toggle = 0, cfg_in_stall = 0;
    logic ep_irq_clr = 0, setup_irq_clr = 0, rd_setup = 0;
    logic [AWB-1:0] rd_addr = 0;
    logic [7:0] rd_data;
    logic hs_valid, ep_nack, ep_stall, ep_toggle, in_ep_stall, setup_pending, ep_irq, setup_irq;
    logic [1:0] hs_code;
    logic [CW-1:0] data_count;

    usbc_ep0_out #(.EP_BYTES(EPB)) dut (.*);

    always #2.5 clk = ~clk;

    int n_chk = 0, n_bad = 0;

    // bench model
    bit m_nack, m_stall, m_tog, m_istall, m_pend, m_eirq, m_sirq;
    int m_cnt;
    logic [7:0] ebuf [EPB];
    bit         ev   [EPB];
    logic [7:0] sbuf [8];
    bit         sv   [8];

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int limit_of(bit is_setup);
        int s = int'(cfg_size);
        if (is_setup) return 8;
        return (s > EPB) ? EPB : s;
    endfunction

    // handshake code by priority: error, pending, halt, hold, toggle
    function automatic int exp_hs(bit is_setup, bit pid1, int len, bit bad_line, output bit acc);
        int lim = limit_of(is_setup);
        bit bad = bad_line || (len > lim) || (is_setup && len != 8);
        acc = 0;
        if (bad) return 0;
        if (is_setup) begin acc = 1; return 1; end
        if (m_pend)  return 2;
        if (m_stall) return 3;
        if (m_nack)  return 2;
        if (pid1 != m_tog) return 1;
        acc = 1;
        return 1;
    endfunction

    task automatic chk_state(string req);
        int mis = 0, first = -1, act = 0, expv = 0;
        chk({ep_nack, ep_stall, ep_toggle, in_ep_stall, setup_pending, ep_irq, setup_irq} ==
            {m_nack, m_stall, m_tog, m_istall, m_pend, m_eirq, m_sirq}, req, "ctrl bits",
            int'({ep_nack, ep_stall, ep_toggle, in_ep_stall, setup_pending, ep_irq, setup_irq}),
            int'({m_nack, m_stall, m_tog, m_istall, m_pend, m_eirq, m_sirq}));
        chk(int'(data_count) == m_cnt, req, "data_count", int'(data_count), m_cnt);
        rd_setup = 0;
        for (int i = 0; i < EPB; i++) begin
            rd_addr = AWB'(i); #0.1;
            if (ev[i] && rd_data !== ebuf[i]) begin
                mis++;
                if (first < 0) begin first = i; act = int'(rd_data); expv = int'(ebuf[i]); end
            end
        end
        rd_setup = 1;
        for (int i = 0; i < 8; i++) begin
            rd_addr = AWB'(i); #0.1;
            if (sv[i] && rd_data !== sbuf[i]) begin
                mis++;
                if (first < 0) begin first = 100 + i; act = int'(rd_data); expv = int'(sbuf[i]); end
            end
        end
        rd_setup = 0;
        chk(mis == 0, req, $sformatf("buffer byte %0d", first), act, expv);
    endtask

    task automatic mcu_cfg(bit n, bit s, bit t, bit is);
        cfg_we = 1; cfg_nack = n; cfg_stall = s; cfg_toggle = t; cfg_in_stall = is;
        tick(); cfg_we = 0;
        m_nack = n; m_stall = s; m_tog = t; m_istall = is;
    endtask

    task automatic clr_ep();
        ep_irq_clr = 1; tick(); ep_irq_clr = 0; m_eirq = 0;
    endtask

    task automatic clr_req(string req);
        setup_irq_clr = 1; tick(); setup_irq_clr = 0; m_sirq = 0; m_pend = 0;
        chk(!setup_pending && !setup_irq, req, "pending/irq after clear",
            int'({setup_pending, setup_irq}), 0);
    endtask

    task automatic send(logic [1:0] kind, logic [3:0] ep, bit pid1, int len,
                        bit crc, bit stf, string req);
        logic [7:0] pk [80];
        bit hit = (ep == 0) && (kind == 2'd0 || kind == 2'd2);
        bit is_setup = (kind == 2'd2);
        bit acc, wrok;
        int code, lim;
        for (int i = 0; i < len; i++) pk[i] = 8'($urandom);
        tok_valid = 1; tok_kind = kind; tok_ep = ep; tick(); tok_valid = 0;
        wrok = is_setup || !(m_pend || m_stall || m_nack || (pid1 != m_tog));
        pkt_start = 1; pkt_data1 = pid1; tick(); pkt_start = 0;
        for (int i = 0; i < len; i++) begin
            rx_valid = 1; rx_byte = pk[i]; tick();
        end
        rx_valid = 0;
        pkt_end = 1; crc_err = crc; stuff_err = stf;
        chk(hs_valid == 0, "R12", "hs_valid before end", int'(hs_valid), 0);
        tick();
        pkt_end = 0; crc_err = 0; stuff_err = 0;
        if (!hit) begin
            chk(hs_valid == 0, "R11", "hs_valid for foreign token", int'(hs_valid), 0);
        end else begin
            code = exp_hs(is_setup, pid1, len, crc || stf, acc);
            chk(hs_valid == 1 && int'(hs_code) == code, req, "handshake",
                hs_valid ? int'(hs_code) : -1, code);
            lim = limit_of(is_setup);
            if (wrok)
                for (int i = 0; i < len && i < lim; i++) begin
                    if (is_setup) begin sbuf[i] = pk[i]; sv[i] = 1; end
                    else          begin ebuf[i] = pk[i]; ev[i] = 1; end
                end
            if (acc) begin
                if (is_setup) begin
                    m_pend = 1; m_sirq = 1; m_stall = 0; m_istall = 0; m_tog = 1;
                end else begin
                    m_cnt = len; m_tog = ~m_tog; m_nack = 1; m_eirq = 1;
                end
            end
        end
        tick();
        chk(hs_valid == 0, "R12", "hs_valid pulse width", int'(hs_valid), 0);
        chk_state(req);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd4051);
        for (int i = 0; i < EPB; i++) ev[i] = 0;
        for (int i = 0; i < 8; i++) sv[i] = 0;
        m_nack = 1; m_stall = 0; m_tog = 0; m_istall = 0; m_pend = 0;
        m_eirq = 0; m_sirq = 0; m_cnt = 0;
        rst = 1; tick(); tick(); rst = 0; tick();
        chk_state("R13");

        // hold set after reset
        send(2'd0, 0, 0, 4, 0, 0, "R2");
        // open, accept
        mcu_cfg(0, 0, 0, 0);
        send(2'd0, 0, 0, 5, 0, 0, "R1");
        send(2'd0, 0, 1, 6, 0, 0, "R2");
        clr_ep();
        mcu_cfg(0, 0, 1, 0);
        send(2'd0, 0, 1, 3, 0, 0, "R8");
        // halt beats hold
        mcu_cfg(1, 1, 0, 1);
        send(2'd0, 0, 0, 2, 0, 0, "R3");
        // request accepted despite halt and hold
        send(2'd2, 0, 0, 8, 0, 0, "R5");
        // pending beats halt and open hold
        mcu_cfg(0, 1, 1, 0);
        send(2'd0, 0, 1, 4, 0, 0, "R6");
        clr_req("R7");
        // errors
        mcu_cfg(0, 0, 0, 0);
        send(2'd0, 0, 0, 7, 1, 0, "R4");
        send(2'd0, 0, 0, 7, 0, 1, "R4");
        // overflow and bad request length
        cfg_size = CW'(16);
        send(2'd0, 0, 0, 17, 0, 0, "R9");
        send(2'd0, 0, 0, 16, 0, 0, "R1");
        mcu_cfg(0, 0, 1, 0);
        send(2'd2, 0, 0, 7, 0, 0, "R9");
        // toggle mismatch
        send(2'd0, 0, 0, 9, 0, 0, "R10");
        // foreign endpoint and IN token
        send(2'd0, 4'd3, 1, 5, 0, 0, "R11");
        send(2'd1, 0, 1, 5, 0, 0, "R11");
        send(2'd3, 0, 1, 5, 0, 0, "R11");

        // constrained random phase
        for (int it = 0; it < 300; it++) begin
            int op = int'($urandom_range(0, 9));
            if (op == 0) begin
                mcu_cfg(1'($urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom));
            end else if (op == 1) begin
                mcu_cfg(0, 0, 1'($urandom), 0);
            end else if (op == 2) begin
                clr_ep();
            end else if (op == 3) begin
                clr_req("R7");
            end else if (op == 4) begin
                logic [CW-1:0] sz [4] = '{CW'(8), CW'(16), CW'(64), CW'(100)};
                cfg_size = sz[$urandom_range(0, 3)];
            end else begin
                logic [1:0] k  = ($urandom_range(0, 4) == 0) ? 2'd2 : 2'($urandom_range(0, 3));
                logic [3:0] e  = ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'd0;
                int ln = (k == 2'd2) ? int'($urandom_range(7, 9)) : int'($urandom_range(0, 70));
                bit cr = ($urandom_range(0, 9) == 0);
                bit sf = ($urandom_range(0, 11) == 0);
                send(k, e, 1'($urandom), ln, cr, sf, "R12");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule